// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a processor on an on-chip register bus talk to an external Ethernet PHY over the two-wire management interface, using clause 22 frames. Software first checks that the controller is idle. It then writes a single command word. That word holds the PHY address, the register number, a direction bit and, for a write, the 16-bit value. The block builds the full 64-bit frame, shifts it out on MDIO and generates MDC itself.

The command word also holds the status. While the frame is in progress a busy flag is set, and command writes are refused. When a read frame completes, the returned 16 bits appear in the low field of the same word and a read-valid flag is raised. Software keeps polling until one of these flags changes.

A second small register, at bus address 1, stores the port's own 5-bit PHY address. Software can read it and write it at any time.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: The command word at bus address 0 reads back as data [15:0], PHY address [20:16], register number [25:21], direction [26] (1 = read, 0 = write), read-valid [27] and busy [28]. Bits [31:29] read as zero, and the whole word is zero after reset.
- R2: A command write is refused while busy [28] is set. The stored fields do not change, and the frame in progress continues unchanged.
- R3: Busy sets on the clock edge that accepts a command. It clears on the edge that ends the last data bit, which is 128*MDC_HALF system clocks after the accepting edge.
- R4: Each frame starts with a 32-bit preamble of ones. Then come start bits 01, the opcode (10 for read, 01 for write), the 5-bit PHY address and then the 5-bit register number, both sent MSB first.
- R5: In a write frame, the turnaround bits are 10 and the 16 data bits follow MSB first. The MDIO output enable stays asserted for all 64 bits.
- R6: In a read frame, the output enable is deasserted for the two turnaround bits and the 16 data bits (frame bits 46 to 63). The output enable is also deasserted whenever the block is idle.
- R7: In a read frame, the data bits are sampled from MDIO at the rising edge of MDC. At the end of the frame they are placed in data [15:0], first received bit at bit 15, and read-valid [27] is set.
- R8: When a new command is accepted, read-valid [27] is cleared.
- R9: The register at bus address 1 stores bits [4:0] of a bus write. It reads back in bits [4:0], with bits [31:5] at zero. Its reset value is 0.
- R10: MDC stays low while the block is idle.
- R11: During a frame, MDC is high for MDC_HALF system clocks and low for MDC_HALF system clocks, so one period is 2*MDC_HALF. MDIO changes only on the falling edge of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 = command word, 1 = own PHY address |
| busWrData | input | 27 | Write data (command fields [26:0]) |
| busRdData | output | 32 | Read data of the addressed register |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input value |

## Verification
Write frames are run for all 32 PHY addresses. Each uses a different register number and data value, so any swapped, shifted or mis-ordered field position shows up in the captured frame. Read frames drive the patterns all-zero, all-one, the two end bits alone, alternating bits and one irregular value into MDIO. These separate the bit order, off-by-one sampling and stuck data bits. One frame gets a colliding command in the middle, which shows whether a refused write is really ignored. A write command issued after a completed read shows that read-valid is cleared.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = 6;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
  } mdio_stb_t;
endpackage

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWrite,
  input  logic      isRead,
  output mdio_stb_t stb,
  output logic      mdc,
  output logic      mdioOe
);
  localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic             mdcQ;
  logic [CNT_W-1:0] bitCnt;
  logic             tick;

  always_comb begin
    tick       = running && (divCnt == DIV_W'(MDC_HALF - 1));
    stb.load   = cmdWrite && !running;
    stb.shift  = tick && mdcQ;
    stb.sample = tick && !mdcQ && isRead && (bitCnt >= CNT_W'(DATA_FIRST));
    stb.finish = tick && mdcQ && (bitCnt == CNT_W'(FRAME_BITS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      mdcQ    <= 1'b0;
      bitCnt  <= '0;
    end else if (stb.load) begin
      running <= 1'b1;
      divCnt  <= '0;
      mdcQ    <= 1'b0;
      bitCnt  <= '0;
    end else if (running) begin
      if (tick) begin
        divCnt <= '0;
        mdcQ   <= ~mdcQ;
        if (mdcQ) bitCnt <= bitCnt + 1'b1;
        if (stb.finish) running <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mdc    = mdcQ;
  assign mdioOe = running && !(isRead && (bitCnt >= CNT_W'(TA_FIRST)));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdio_stb_t   stb,
  input  logic        selfWrite,
  input  logic [26:0] wrData,
  input  logic        mdioIn,
  output logic [31:0] cmdWord,
  output logic [ADDR_W-1:0] selfPhy,
  output logic        isRead,
  output logic        mdioOut
);
  logic [DATA_W-1:0]     dataQ;
  logic [ADDR_W-1:0]     phyQ;
  logic [ADDR_W-1:0]     regQ;
  logic                  rdQ;
  logic                  validQ;
  logic                  busyQ;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [DATA_W-1:0]     rxQ;
  logic [ADDR_W-1:0]     selfQ;
  logic [FRAME_BITS-1:0] frameNext;

  always_comb begin
    frameNext = {32'hFFFF_FFFF, 2'b01,
                 wrData[26] ? 2'b10 : 2'b01,
                 wrData[20:16], wrData[25:21],
                 2'b10,
                 wrData[26] ? 16'h0000 : wrData[15:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ  <= '0;
      phyQ   <= '0;
      regQ   <= '0;
      rdQ    <= 1'b0;
      validQ <= 1'b0;
      busyQ  <= 1'b0;
      shiftQ <= '0;
      rxQ    <= '0;
      selfQ  <= '0;
    end else begin
      if (stb.load) begin
        dataQ  <= wrData[15:0];
        phyQ   <= wrData[20:16];
        regQ   <= wrData[25:21];
        rdQ    <= wrData[26];
        validQ <= 1'b0;
        busyQ  <= 1'b1;
        shiftQ <= frameNext;
      end else begin
        if (stb.shift) shiftQ <= {shiftQ[FRAME_BITS-2:0], 1'b0};
        if (stb.finish) begin
          busyQ <= 1'b0;
          if (rdQ) begin
            dataQ  <= rxQ;
            validQ <= 1'b1;
          end
        end
      end
      if (stb.sample) rxQ <= {rxQ[DATA_W-2:0], mdioIn};
      if (selfWrite) selfQ <= wrData[ADDR_W-1:0];
    end
  end

  assign cmdWord = {3'b000, busyQ, validQ, rdQ, regQ, phyQ, dataQ};
  assign selfPhy = selfQ;
  assign isRead  = rdQ;
  assign mdioOut = shiftQ[FRAME_BITS-1];
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busAddr,
  input  logic [26:0] busWrData,
  output logic [31:0] busRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdio_stb_t         stb;
  logic [31:0]       cmdWord;
  logic [ADDR_W-1:0] selfPhy;
  logic              isRead;

  mdio_seq #(.MDC_HALF(MDC_HALF)) u_seq (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (busWrEn && !busAddr),
    .isRead   (isRead),
    .stb      (stb),
    .mdc      (mdc),
    .mdioOe   (mdioOe)
  );

  mdio_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .selfWrite (busWrEn && busAddr),
    .wrData    (busWrData),
    .mdioIn    (mdioIn),
    .cmdWord   (cmdWord),
    .selfPhy   (selfPhy),
    .isRead    (isRead),
    .mdioOut   (mdioOut)
  );

  assign busRdData = busAddr ? {27'd0, selfPhy} : cmdWord;
endmodule

// File: rtl/mdio_chk.sv
module mdio_chk #(
  parameter int MDC_HALF = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic        busAddr,
  input logic [31:0] cmdWord,
  input logic        mdc,
  input logic        mdioOe
);
  p_mdc_idle_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cmdWord[28] |-> !mdc);

  p_busy_locks_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWord[28] && busWrEn && !busAddr) |=> (cmdWord[26:16] == $past(cmdWord[26:16])));

  p_accept_clears_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWord[28] && busWrEn && !busAddr) |=> (cmdWord[28] && !cmdWord[27]));

  p_oe_only_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> cmdWord[28]);

  p_valid_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdWord[27]) |-> ($fell(cmdWord[28]) && cmdWord[26]));

  p_mdc_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((MDC_HALF > 1) && !$stable(mdc)) |=> $stable(mdc));
endmodule

bind mdio_cmd_ctrl mdio_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busWrEn (busWrEn),
  .busAddr (busAddr),
  .cmdWord (cmdWord),
  .mdc     (mdc),
  .mdioOe  (mdioOe)
);

// File: tb/test_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module test_mdio_cmd_ctrl;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busAddr = 1'b0;
  logic [26:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] capOut, capOe;
  int          busyCycles;
  int          periodErr;

  always #2 clk = ~clk;

  mdio_cmd_ctrl #(.MDC_HALF(HALF)) i_mdio_cmd_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expFrame(input bit rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f;
    f[63:32] = 32'hFFFF_FFFF;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = phy;
    f[22:18] = rg;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  // Issues a command and follows the frame until busy drops.
  task automatic runFrame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d, input logic [15:0] rxPat, input bit collide);
    int idx = 0;
    int lastRise = -1;
    logic prevMdc = 1'b0;
    capOut = '0; capOe = '0; busyCycles = 0; periodErr = 0;
    @(negedge clk);
    busAddr = 1'b0;
    busWrData = {rd, rg, phy, d};
    busWrEn = 1'b1;
    mdioIn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R3 busy set on accept", {63'd0, busRdData[28]}, 64'd1);
    check("R8 read-valid cleared on accept", {63'd0, busRdData[27]}, 64'd0);
    while (busRdData[28] === 1'b1 && busyCycles < 2000) begin
      busyCycles++;
      if (mdc && !prevMdc) begin
        capOut[63-idx] = mdioOut;
        capOe[63-idx]  = mdioOe;
        if (lastRise >= 0 && (busyCycles - lastRise) != 2*HALF) periodErr++;
        lastRise = busyCycles;
        idx++;
      end
      if (!mdc) mdioIn = (idx >= 48 && idx < 64) ? rxPat[63-idx] : 1'b1;
      prevMdc = mdc;
      if (collide && busyCycles == 50) begin
        busWrData = {~rd, ~rg, ~phy, ~d};
        busWrEn = 1'b1;
      end else begin
        busWrEn = 1'b0;
      end
      @(negedge clk);
    end
    busWrEn = 1'b0;
    check("R3 busy duration", busyCycles, 128*HALF);
    check("R11 MDC period", periodErr, 0);
    check("R10 MDC low when idle", {63'd0, mdc}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busAddr = 1'b0;
    #0;
    check("R1 reset command word", busRdData, 0);
    check("R10 reset MDC", {63'd0, mdc}, 0);
    check("R6 reset OE", {63'd0, mdioOe}, 0);
    busAddr = 1'b1;
    #1;
    check("R9 reset own PHY", busRdData, 0);

    // R9: only five bits kept
    @(negedge clk);
    busAddr = 1'b1; busWrData = 27'h7FF_FFF5; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R9 own PHY readback", busRdData, 32'h15);
    busAddr = 1'b0;

    // Write sweep over all PHY addresses (R4, R5, R1, R2)
    for (int p = 0; p < 32; p++) begin
      logic [4:0]  ph = 5'(p);
      logic [4:0]  rg = 5'(31 - p);
      logic [15:0] d  = 16'(p * 16'h0841) ^ 16'hA5C3;
      runFrame(1'b0, ph, rg, d, 16'h0, p == 7);
      check("R4 R5 write frame", capOut, expFrame(1'b0, ph, rg, d));
      check("R5 OE in write", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
      check(p == 7 ? "R2 refused write kept fields" : "R1 command readback",
            busRdData, {3'b000, 1'b0, 1'b0, 1'b0, rg, ph, d});
    end

    // Read patterns (R6, R7, R8)
    begin
      logic [15:0] pats [6] = '{16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE, 16'hA5A5, 16'h1234};
      for (int k = 0; k < 6; k++) begin
        logic [4:0] ph = 5'((k * 5 + 3) % 32);
        logic [4:0] rg = 5'((k * 11 + 1) % 32);
        runFrame(1'b1, ph, rg, 16'h0, pats[k], 1'b0);
        check("R4 read frame header", {18'd0, capOut[63:18]},
              {18'd0, expFrame(1'b1, ph, rg, 16'h0) >> 18});
        check("R6 OE released in read", capOe, 64'hFFFF_FFFF_FFFC_0000);
        check("R7 read data and valid", busRdData,
              {3'b000, 1'b0, 1'b1, 1'b1, rg, ph, pats[k]});
      end
    end

    // R8: a write command after a read clears read-valid
    runFrame(1'b0, 5'd9, 5'd4, 16'hBEEF, 16'h0, 1'b0);
    check("R8 valid clear after later write", {63'd0, busRdData[27]}, 0);
    busAddr = 1'b1;
    #1;
    check("R9 own PHY unchanged by frames", busRdData, 32'h15);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule